// File: doc/BRIEF.md
# Banked CPU Address Decoder

This block sits between an 8-bit CPU's 16-bit memory port and the memories and register files of a handheld-console memory map. For every request it picks one physical target (fixed or switchable cartridge ROM, video RAM, cartridge save RAM, the real-time-clock register window, the two work-RAM windows, sprite attribute RAM, I/O registers, high RAM or the interrupt-enable register), raises that target's select, and supplies an offset local to the target. Requests that land on a blocked or empty location raise no select. A read returns 0xFF in that case.

The decoder keeps three pieces of state: the switchable work-RAM bank number and the two gates for save RAM and the clock window. Writes into the cartridge ROM area never reach memory. They are forwarded as a strobe with address and data to the bank controller that lives outside this block. Video timing enters as a 2-bit mode value that decides whether sprite RAM may be touched.

The request side is a valid-only stream. The decoder accepts a request in every cycle that `req_valid` is high and exerts no back-pressure, so it has no ready output. Each accepted read produces exactly one response beat, `rsp_valid`, in the following cycle. The consumer must take that beat, because it cannot stall it. Target memories return data one cycle after their select.

Top module: `banked_addr_decoder`

## Requirements
- R1: Address bits 15:12 pick the target. For 0x0-0x3 the target is fixed ROM (select bit 0, offset addr[13:0]). For 0x4-0x7 it is switchable ROM (bit 1, offset addr[13:0]). For 0x8-0x9 it is video RAM (bit 2, offset addr[12:0]). For 0xC it is work RAM bank 0 (bit 5, offset addr[11:0]).
- R2: Addresses 0xE000-0xEFFF alias work RAM bank 0 (bit 5, offset addr[11:0]). Addresses 0xF000-0xFDFF alias the switchable work-RAM window in the same way as 0xD000-0xDFFF.
- R3: The switchable work-RAM window 0xD000-0xDFFF uses select bit 6 with offset bank*0x1000 + addr[11:0]. A write on the bank port keeps only value bits 2:0, and a result of 0 becomes 1. The bank is 1 after reset.
- R4: Sprite RAM 0xFE00-0xFE9F (bit 7, offset addr[7:0]) is selected only while the video mode is 0 or 1. In modes 2 and 3 no select is raised, no write enable is raised, and a read returns 0xFF.
- R5: Addresses 0xFEA0-0xFEFF raise no select and no write enable, and reads there return 0xFF.
- R6: In 0xA000-0xBFFF the clock gate has priority and selects bit 4 with offset 0. Otherwise the save-RAM gate selects bit 3 with offset addr[12:0]. With neither gate open, nothing is selected and reads return 0xFF. Reset closes both gates. A gate write loads both gates at once.
- R7: 0xFF00-0xFF7F selects I/O (bit 8, offset addr[6:0]). 0xFF80-0xFFFE selects high RAM (bit 9, offset addr[6:0]). 0xFFFF selects the interrupt-enable register (bit 10, offset 0).
- R8: A write to 0x0000-0x7FFF raises `mbc_wr` with `mbc_addr` and `mbc_data` equal to the request, and raises no select and no `mem_we`.
- R9: Each accepted read gives `rsp_valid` high in the next cycle with `rsp_data` equal to the selected target's read data in that cycle, or 0xFF if nothing was selected. No other cycle has `rsp_valid`.
- R10: At most one select is high, only while `req_valid` is high. An unselected target's offset is 0. `mem_we` is high exactly for a valid write that raises a select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | CPU address |
| req_wdata | input | 8 | Write data |
| vid_mode | input | 2 | Current video mode |
| wbank_we | input | 1 | Load the work-RAM bank number |
| wbank_data | input | 8 | Bank value (bits 2:0 used) |
| gate_we | input | 1 | Load both external-RAM gates |
| gate_sram | input | 1 | Save-RAM gate value |
| gate_rtc | input | 1 | Clock-window gate value |
| reg_sel | output | 11 | One select per target |
| reg_off | output | 11x16 | Offset per target |
| mem_we | output | 1 | Write enable for the selected target |
| mem_wdata | output | 8 | Write data to targets |
| reg_rdata | input | 11x8 | Read data from each target |
| rsp_valid | output | 1 | Read response beat |
| rsp_data | output | 8 | Read response data |
| mbc_wr | output | 1 | ROM-area write strobe |
| mbc_addr | output | 16 | ROM-area write address |
| mbc_data | output | 8 | ROM-area write data |

## Verification
A wrong bank number or gate state does not show up until the next access to the switchable work-RAM window or the cartridge RAM window. It then appears in the same cycle as a wrong offset or as a missing or wrong select. The test therefore interleaves bank and gate writes with accesses to those windows. A corrupted registered read select shows one cycle after the read, as a response carrying another target's data or a spurious 0xFF. An address-decode error is visible at once on the selects and offsets. The test compares every cycle against a model, so each of these faults is caught at its first occurrence.

// File: rtl/adec_pkg.sv
package adec_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int OFF_W  = 16;
  localparam int BANK_W = 3;
  localparam int NSEL   = 11;
  localparam int IDX_W  = $clog2(NSEL + 1);

  typedef enum logic [IDX_W-1:0] {
    T_ROM0  = 4'd0,
    T_ROMX  = 4'd1,
    T_VRAM  = 4'd2,
    T_SRAM  = 4'd3,
    T_RTC   = 4'd4,
    T_WRAM0 = 4'd5,
    T_WRAMX = 4'd6,
    T_OAM   = 4'd7,
    T_IO    = 4'd8,
    T_HRAM  = 4'd9,
    T_IE    = 4'd10,
    T_NONE  = 4'd15
  } target_e;

  localparam logic [ADDR_W-1:0] OAM_BASE  = 16'hFE00;
  localparam logic [ADDR_W-1:0] GAP_BASE  = 16'hFEA0;
  localparam logic [ADDR_W-1:0] IO_BASE   = 16'hFF00;
  localparam logic [ADDR_W-1:0] HRAM_BASE = 16'hFF80;
  localparam logic [ADDR_W-1:0] IE_ADDR   = 16'hFFFF;
  localparam logic [DATA_W-1:0] OPEN_BUS  = '1;
endpackage

// File: rtl/adec_bank.sv
module adec_bank
  import adec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wbank_we,
  input  logic [DATA_W-1:0] wbank_data,
  input  logic              gate_we,
  input  logic              gate_sram,
  input  logic              gate_rtc,
  output logic [BANK_W-1:0] bank,
  output logic              sram_en,
  output logic              rtc_en
);
  logic [BANK_W-1:0] bank_raw;
  assign bank_raw = wbank_data[BANK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank    <= BANK_W'(1);
      sram_en <= 1'b0;
      rtc_en  <= 1'b0;
    end else begin
      if (wbank_we)
        bank <= (bank_raw == '0) ? BANK_W'(1) : bank_raw;
      if (gate_we) begin
        sram_en <= gate_sram;
        rtc_en  <= gate_rtc;
      end
    end
  end

  p_bank_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bank != '0);

  p_bank_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wbank_we && (wbank_data[BANK_W-1:0] != '0) |=> bank == $past(wbank_data[BANK_W-1:0]));

  p_gate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_we |=> $stable(sram_en) && $stable(rtc_en));
endmodule

// File: rtl/adec_region.sv
module adec_region
  import adec_pkg::*;
(
  input  logic                        req_valid,
  input  logic                        req_we,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [1:0]                  vid_mode,
  input  logic [BANK_W-1:0]           bank,
  input  logic                        sram_en,
  input  logic                        rtc_en,
  output target_e                     target,
  output logic [NSEL-1:0]             sel,
  output logic [NSEL-1:0][OFF_W-1:0]  off,
  output logic                        rom_wr
);
  logic [OFF_W-1:0] off_v;
  logic             rom_area;
  logic             oam_open;

  assign oam_open = ~vid_mode[1];
  assign rom_area = ~req_addr[15];

  always_comb begin
    target = T_NONE;
    off_v  = '0;
    unique case (req_addr[15:12])
      4'h0, 4'h1, 4'h2, 4'h3: begin
        target = T_ROM0;
        off_v  = OFF_W'(req_addr[13:0]);
      end
      4'h4, 4'h5, 4'h6, 4'h7: begin
        target = T_ROMX;
        off_v  = OFF_W'(req_addr[13:0]);
      end
      4'h8, 4'h9: begin
        target = T_VRAM;
        off_v  = OFF_W'(req_addr[12:0]);
      end
      4'hA, 4'hB: begin
        if (rtc_en) begin
          target = T_RTC;
        end else if (sram_en) begin
          target = T_SRAM;
          off_v  = OFF_W'(req_addr[12:0]);
        end
      end
      4'hC, 4'hE: begin
        target = T_WRAM0;
        off_v  = OFF_W'(req_addr[11:0]);
      end
      4'hD: begin
        target = T_WRAMX;
        off_v  = OFF_W'({bank, req_addr[11:0]});
      end
      default: begin
        if (req_addr < OAM_BASE) begin
          target = T_WRAMX;
          off_v  = OFF_W'({bank, req_addr[11:0]});
        end else if (req_addr < GAP_BASE) begin
          if (oam_open) begin
            target = T_OAM;
            off_v  = OFF_W'(req_addr[7:0]);
          end
        end else if (req_addr < IO_BASE) begin
          target = T_NONE;
        end else if (req_addr < HRAM_BASE) begin
          target = T_IO;
          off_v  = OFF_W'(req_addr[6:0]);
        end else if (req_addr != IE_ADDR) begin
          target = T_HRAM;
          off_v  = OFF_W'(req_addr[6:0]);
        end else begin
          target = T_IE;
        end
      end
    endcase
    if (rom_area && req_we)
      target = T_NONE;
  end

  assign rom_wr = req_valid & req_we & rom_area;

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    logic hit;
    assign hit    = req_valid && (target == target_e'(g));
    assign sel[g] = hit;
    assign off[g] = hit ? off_v : '0;
  end
endmodule

// File: rtl/adec_rsp.sv
module adec_rsp
  import adec_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_we,
  input  target_e                     target,
  input  logic [NSEL-1:0][DATA_W-1:0] rdata,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_data
);
  target_e tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      tgt_q     <= T_NONE;
    end else begin
      rsp_valid <= req_valid & ~req_we;
      if (req_valid & ~req_we)
        tgt_q <= target;
    end
  end

  always_comb begin
    rsp_data = '0;
    if (rsp_valid) begin
      if (tgt_q == T_NONE || int'(tgt_q) >= NSEL)
        rsp_data = OPEN_BUS;
      else
        rsp_data = rdata[tgt_q];
    end
  end

  p_rsp_follows_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_we |=> rsp_valid);

  p_rsp_only_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rsp_valid);
endmodule

// File: rtl/banked_addr_decoder.sv
module banked_addr_decoder
  import adec_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_we,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  input  logic [1:0]                  vid_mode,
  input  logic                        wbank_we,
  input  logic [DATA_W-1:0]           wbank_data,
  input  logic                        gate_we,
  input  logic                        gate_sram,
  input  logic                        gate_rtc,
  output logic [NSEL-1:0]             reg_sel,
  output logic [NSEL-1:0][OFF_W-1:0]  reg_off,
  output logic                        mem_we,
  output logic [DATA_W-1:0]           mem_wdata,
  input  logic [NSEL-1:0][DATA_W-1:0] reg_rdata,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_data,
  output logic                        mbc_wr,
  output logic [ADDR_W-1:0]           mbc_addr,
  output logic [DATA_W-1:0]           mbc_data
);
  logic [BANK_W-1:0] bank;
  logic              sram_en;
  logic              rtc_en;
  target_e           target;

  adec_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wbank_we   (wbank_we),
    .wbank_data (wbank_data),
    .gate_we    (gate_we),
    .gate_sram  (gate_sram),
    .gate_rtc   (gate_rtc),
    .bank       (bank),
    .sram_en    (sram_en),
    .rtc_en     (rtc_en)
  );

  adec_region u_region (
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .vid_mode  (vid_mode),
    .bank      (bank),
    .sram_en   (sram_en),
    .rtc_en    (rtc_en),
    .target    (target),
    .sel       (reg_sel),
    .off       (reg_off),
    .rom_wr    (mbc_wr)
  );

  adec_rsp u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .target    (target),
    .rdata     (reg_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign mem_we    = req_valid & req_we & (|reg_sel);
  assign mem_wdata = req_wdata;
  assign mbc_addr  = req_addr;
  assign mbc_data  = req_wdata;

  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_sel));

  p_sel_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> reg_sel == '0);

  p_rom_write_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_we && !req_addr[15] |-> mbc_wr && reg_sel == '0 && !mem_we);

  p_oam_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vid_mode[1] |-> !reg_sel[T_OAM]);

  p_gap_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_addr >= GAP_BASE && req_addr < IO_BASE |-> reg_sel == '0);
endmodule

// File: tb/sim_banked_addr_decoder.sv
module sim_banked_addr_decoder;
  import adec_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [1:0] vid_mode = '0;
  logic wbank_we = 1'b0;
  logic [7:0] wbank_data = '0;
  logic gate_we = 1'b0, gate_sram = 1'b0, gate_rtc = 1'b0;
  logic [NSEL-1:0] reg_sel;
  logic [NSEL-1:0][OFF_W-1:0] reg_off;
  logic mem_we;
  logic [7:0] mem_wdata;
  logic [NSEL-1:0][7:0] reg_rdata;
  logic rsp_valid;
  logic [7:0] rsp_data;
  logic mbc_wr;
  logic [15:0] mbc_addr;
  logic [7:0] mbc_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [2:0] m_bank = 3'd1;
  bit m_sram = 1'b0, m_rtc = 1'b0;
  bit pend = 1'b0;
  logic [7:0] pend_data = '0;

  always #5 clk = ~clk;

  function automatic logic [7:0] rd_of(int i);
    return 8'(i * 19 + 5);
  endfunction

  for (genvar g = 0; g < NSEL; g++) begin : g_rd
    assign reg_rdata[g] = rd_of(g);
  end

  banked_addr_decoder u0 (.*);

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] a, input bit we, input logic [1:0] md,
                                output int idx, output logic [15:0] off, output bit mbc,
                                output string tag);
    int ia = int'(a);
    idx = -1; off = '0; mbc = 1'b0; tag = "R1";
    if (ia < 'h8000) begin
      tag = "R1";
      if (we) begin mbc = 1'b1; tag = "R8"; end
      else begin idx = (ia < 'h4000) ? 0 : 1; off = 16'(ia % 'h4000); end
    end else if (ia < 'hA000) begin idx = 2; off = 16'(ia - 'h8000); end
    else if (ia < 'hC000) begin
      tag = "R6";
      if (m_rtc) idx = 4;
      else if (m_sram) begin idx = 3; off = 16'(ia - 'hA000); end
    end else if (ia < 'hD000) begin idx = 5; off = 16'(ia - 'hC000); end
    else if (ia < 'hE000) begin tag = "R3"; idx = 6; off = 16'(int'(m_bank) * 4096 + ia - 'hD000); end
    else if (ia < 'hF000) begin tag = "R2"; idx = 5; off = 16'(ia - 'hE000); end
    else if (ia < 'hFE00) begin tag = "R2"; idx = 6; off = 16'(int'(m_bank) * 4096 + ia - 'hF000); end
    else if (ia < 'hFEA0) begin tag = "R4"; if (md < 2) begin idx = 7; off = 16'(ia - 'hFE00); end end
    else if (ia < 'hFF00) tag = "R5";
    else if (ia < 'hFF80) begin tag = "R7"; idx = 8; off = 16'(ia - 'hFF00); end
    else if (ia < 'hFFFF) begin tag = "R7"; idx = 9; off = 16'(ia - 'hFF80); end
    else begin tag = "R7"; idx = 10; end
  endfunction

  task automatic step(input bit v, input bit we, input logic [15:0] a, input logic [1:0] md,
                      input bit bwe, input logic [7:0] bd, input bit gwe, input bit gs, input bit gr);
    int idx; logic [15:0] off; bit mbc; string tag;
    logic [NSEL-1:0] e_sel;
    logic [NSEL-1:0][OFF_W-1:0] e_off;
    @(negedge clk);
    req_valid = v; req_we = we; req_addr = a; vid_mode = md;
    req_wdata = 8'($urandom);
    wbank_we = bwe; wbank_data = bd; gate_we = gwe; gate_sram = gs; gate_rtc = gr;
    #1;
    chk("R9 rsp_valid", 256'(rsp_valid), 256'(pend));
    if (pend) chk("R9 rsp_data", 256'(rsp_data), 256'(pend_data));
    model(a, we, md, idx, off, mbc, tag);
    e_sel = '0; e_off = '0;
    if (v && idx >= 0) begin e_sel[idx] = 1'b1; e_off[idx] = off; end
    chk({tag, " sel"}, 256'(reg_sel), 256'(e_sel));
    chk({tag, " off"}, 256'(reg_off), 256'(e_off));
    chk("R10 mem_we", 256'(mem_we), 256'(v && we && idx >= 0));
    chk("R8 mbc_wr", 256'(mbc_wr), 256'(v && mbc));
    if (v && mbc) chk("R8 mbc_addr_data", 256'({mbc_addr, mbc_data}), 256'({a, req_wdata}));
    pend = v && !we;
    pend_data = (idx >= 0) ? rd_of(idx) : 8'hFF;
    @(posedge clk);
    if (bwe) m_bank = (bd[2:0] == 3'd0) ? 3'd1 : bd[2:0];
    if (gwe) begin m_sram = gs; m_rtc = gr; end
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] md);
    step(1'b1, 1'b0, a, md, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
  endtask

  function automatic logic [15:0] rand_addr();
    case ($urandom_range(0, 7))
      0: return 16'($urandom);
      1: return 16'($urandom_range('hA000, 'hBFFF));
      2: return 16'($urandom_range('hD000, 'hDFFF));
      3: return 16'($urandom_range('hE000, 'hFDFF));
      4: return 16'($urandom_range('hFE00, 'hFEFF));
      5: return 16'($urandom_range('hFF00, 'hFFFF));
      6: return 16'($urandom_range('h0000, 'h7FFF));
      default: return 16'($urandom_range('h8000, 'hCFFF));
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset rsp_valid", 256'(rsp_valid), 256'(0));
    rst_n = 1'b1;
    // R3 reset bank 1, R6 reset gates closed
    rd(16'hD123, 2'd0);
    rd(16'hA010, 2'd0);
    // R3 bank value 0 maps to 1, upper bits ignored
    step(1'b0, 1'b0, 16'h0, 2'd0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    rd(16'hD001, 2'd0);
    step(1'b0, 1'b0, 16'h0, 2'd0, 1'b1, 8'h08, 1'b0, 1'b0, 1'b0);
    rd(16'hF002, 2'd0);
    step(1'b0, 1'b0, 16'h0, 2'd0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    rd(16'hDFFF, 2'd0);
    // R6 priority with both gates open, then save RAM only
    step(1'b0, 1'b0, 16'h0, 2'd0, 1'b0, 8'h0, 1'b1, 1'b1, 1'b1);
    rd(16'hB7FF, 2'd0);
    step(1'b0, 1'b0, 16'h0, 2'd0, 1'b0, 8'h0, 1'b1, 1'b1, 1'b0);
    rd(16'hB7FF, 2'd0);
    step(1'b1, 1'b1, 16'hA001, 2'd0, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
    // R4 sprite RAM by mode, R5 gap
    rd(16'hFE9F, 2'd1);
    rd(16'hFE9F, 2'd2);
    step(1'b1, 1'b1, 16'hFE00, 2'd3, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
    rd(16'hFEA0, 2'd0);
    step(1'b1, 1'b1, 16'hFEFF, 2'd0, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
    // R7 boundaries, R8 ROM writes
    rd(16'hFF7F, 2'd0); rd(16'hFF80, 2'd0); rd(16'hFFFE, 2'd0); rd(16'hFFFF, 2'd0);
    step(1'b1, 1'b1, 16'h2000, 2'd0, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 16'h7FFF, 2'd0, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
    rd(16'h3FFF, 2'd0); rd(16'h4000, 2'd0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, rand_addr(),
           2'($urandom), $urandom_range(0, 15) == 0, 8'($urandom),
           $urandom_range(0, 15) == 0, 1'($urandom), 1'($urandom));
    end
    step(1'b0, 1'b0, 16'h0, 2'd0, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule